// File: doc/BRIEF.md
# Dual-Register Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. Two flip-flops sit in the cell, and each one is fed by its own sum term from the logic array. Each flip-flop has its own configuration. It can load its sum term or toggle on it. It can take the shared pin clock or its own product-term clock. It can be cleared at any time by its own asynchronous reset term. One synchronous preset line is common to all cells and forces a register high on its next edge.

The cell drives one pad. The pad value comes from register 0, from register 1 or straight from sum term 0, and then passes through a polarity XOR. A separate output-enable term gates the pad driver. Both register values always return to the array, so either register can be buried while the other drives the pad. The pad level also returns to the array on its own path.

For test, a preload mode writes the raw pad level into the register chosen by a select input. The write happens on that register's clock edge, and the other register holds its value. An active-low power-on reset pulse clears both registers.

Top module: `omc_dual_cell`

## Requirements
- R1: A register in D mode (t_mode = 0) takes the value of its sum term on each edge of its selected clock.
- R2: A register in T mode (t_mode = 1) inverts on an edge of its selected clock when its sum term is 1, and keeps its value on that edge when the sum term is 0.
- R3: When cfg_pt_clk_i[k] = 1, register k is clocked only by rising edges of pt_clk_i[k]. When cfg_pt_clk_i[k] = 0, it is clocked only by rising edges of clk_pin_i.
- R4: While areset_i[k] = 1, register k reads 0 at once, with no clock edge needed. This reset wins over preset, preload and data.
- R5: On an edge of its selected clock with spreset_i = 1 and preload_i = 0, a register loads 1 in either mode. The preset wins over the D and T update.
- R6: With preload_i = 1, an edge on register k's selected clock loads pad_i into register k when preload_sel_i = k, so 0 selects register 0 and 1 selects register 1. The register that is not selected keeps its value. The loaded value is the raw pad level, whatever cfg_inv_i is set to.
- R7: While rst_ni = 0, both registers read 0, and with cfg_osel_i = 0 the pad_o output equals cfg_inv_i.
- R8: pad_o equals the selected source XOR cfg_inv_i. cfg_osel_i = 0 selects register 0 and 1 selects register 1. Values 2 and 3 select sum_i[0] combinationally.
- R9: pad_oe_o follows oe_term_i, and pin_fb_o follows pad_i. reg_fb_o[k] always shows register k, whatever cfg_osel_i is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin_i | input | 1 | Shared pin clock |
| rst_ni | input | 1 | Active-low power-on reset pulse |
| sum_i | input | NREG | Sum term per register |
| pt_clk_i | input | NREG | Product-term clock per register |
| areset_i | input | NREG | Asynchronous reset term per register, active high |
| spreset_i | input | 1 | Shared synchronous preset |
| cfg_t_mode_i | input | NREG | 1 selects T mode, 0 selects D mode |
| cfg_pt_clk_i | input | NREG | 1 selects the product-term clock, 0 selects the pin clock |
| cfg_osel_i | input | OSEL_W | Pad source select |
| cfg_inv_i | input | 1 | Output polarity XOR |
| oe_term_i | input | 1 | Output-enable term |
| preload_i | input | 1 | Preload mode |
| preload_sel_i | input | SEL_W | Register addressed by preload |
| pad_i | input | 1 | Level seen on the pad |
| pad_o | output | 1 | Pad drive value |
| pad_oe_o | output | 1 | Pad driver enable |
| pin_fb_o | output | 1 | Pad input path back to the array |
| reg_fb_o | output | NREG | Register feedback to the array |

## Verification
The hardest states to reach from the ports are those where the two registers disagree on clock source and mode in the same run. Examples are a toggling register on its own product-term clock next to a loading register on the pin clock, or a preset landing on only one of them. To reach them, the bench sweeps all sixteen mode and clock-source combinations. In each combination it fires a mixed series of pin-clock edges and single product-term pulses, which it keeps apart in time, and drives varied sum patterns with one preset step. After every event it compares both feedback bits against a model kept per register. Preload addressing and the async reset's priority are then set up from known register contents that were written earlier by preload.

// File: rtl/omc_pkg.sv
`timescale 1ns/100ps
package omc_pkg;
  localparam int unsigned NREG_DEF = 2;

  typedef struct packed {
    logic t_mode;
    logic pt_clk;
  } reg_cfg_t;
endpackage

// File: rtl/omc_reg_cell.sv
`timescale 1ns/100ps
module omc_reg_cell
  import omc_pkg::*;
(
  input  logic     clk_pin_i,
  input  logic     pt_clk_i,
  input  logic     rst_ni,
  input  logic     areset_i,
  input  logic     spreset_i,
  input  logic     sum_i,
  input  logic     pl_mode_i,
  input  logic     pl_hit_i,
  input  logic     pl_data_i,
  input  reg_cfg_t cfg_i,
  output logic     q_o
);
  logic clk_eff;
  logic arst_n;
  logic q_q;
  logic live_q;  // set on the first clock edge after any reset (assertion support)

  assign clk_eff = cfg_i.pt_clk ? pt_clk_i : clk_pin_i;
  assign arst_n  = rst_ni & ~areset_i;

  // priority: reset, preload, preset, D/T update
  always_ff @(posedge clk_eff or negedge arst_n) begin
    if (!arst_n)              q_q <= 1'b0;
    else if (pl_mode_i) begin
      if (pl_hit_i)           q_q <= pl_data_i;
    end
    else if (spreset_i)       q_q <= 1'b1;
    else if (cfg_i.t_mode)    q_q <= q_q ^ sum_i;
    else                      q_q <= sum_i;
  end

  always_ff @(posedge clk_eff or negedge arst_n) begin
    if (!arst_n) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assign q_o = q_q;

  AST_D_LOADS_SUM: assert property (@(posedge clk_eff) disable iff (!arst_n)
    live_q && $past(!pl_mode_i && !spreset_i && !cfg_i.t_mode) |-> q_q == $past(sum_i)); // R1
  AST_T_TOGGLES: assert property (@(posedge clk_eff) disable iff (!arst_n)
    live_q && $past(!pl_mode_i && !spreset_i && cfg_i.t_mode) |-> q_q == ($past(q_q) ^ $past(sum_i))); // R2
  AST_ARESET_CLEARS: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
    areset_i |-> !q_q); // R4
  AST_PRESET_HIGH: assert property (@(posedge clk_eff) disable iff (!arst_n)
    live_q && $past(!pl_mode_i && spreset_i) |-> q_q); // R5
  AST_PRELOAD_LOADS: assert property (@(posedge clk_eff) disable iff (!arst_n)
    live_q && $past(pl_mode_i && pl_hit_i) |-> q_q == $past(pl_data_i)); // R6
  AST_PRELOAD_HOLDS: assert property (@(posedge clk_eff) disable iff (!arst_n)
    live_q && $past(pl_mode_i && !pl_hit_i) |-> q_q == $past(q_q)); // R6
endmodule

// File: rtl/omc_out_stage.sv
`timescale 1ns/100ps
module omc_out_stage #(
  parameter int unsigned NREG   = 2,
  parameter int unsigned OSEL_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]   q_i,
  input  logic              comb_i,
  input  logic [OSEL_W-1:0] osel_i,
  input  logic              inv_i,
  input  logic              oe_i,
  output logic              pad_o,
  output logic              pad_oe_o
);
  logic src;

  always_comb begin
    src = comb_i;  // any code at or above NREG selects the combinational path
    for (int k = 0; k < NREG; k++) begin
      if (osel_i == OSEL_W'(k)) src = q_i[k];
    end
  end

  assign pad_o    = src ^ inv_i;
  assign pad_oe_o = oe_i;
endmodule

// File: rtl/omc_dual_cell.sv
`timescale 1ns/100ps
module omc_dual_cell
  import omc_pkg::*;
#(
  parameter int unsigned NREG   = NREG_DEF,
  parameter int unsigned SEL_W  = $clog2(NREG),
  parameter int unsigned OSEL_W = $clog2(NREG + 1)
) (
  input  logic              clk_pin_i,
  input  logic              rst_ni,
  input  logic [NREG-1:0]   sum_i,
  input  logic [NREG-1:0]   pt_clk_i,
  input  logic [NREG-1:0]   areset_i,
  input  logic              spreset_i,
  input  logic [NREG-1:0]   cfg_t_mode_i,
  input  logic [NREG-1:0]   cfg_pt_clk_i,
  input  logic [OSEL_W-1:0] cfg_osel_i,
  input  logic              cfg_inv_i,
  input  logic              oe_term_i,
  input  logic              preload_i,
  input  logic [SEL_W-1:0]  preload_sel_i,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              pin_fb_o,
  output logic [NREG-1:0]   reg_fb_o
);
  logic [NREG-1:0] q;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    reg_cfg_t cfg;
    logic     hit;
    assign cfg.t_mode = cfg_t_mode_i[k];
    assign cfg.pt_clk = cfg_pt_clk_i[k];
    assign hit        = (preload_sel_i == SEL_W'(k));

    omc_reg_cell u_reg (
      .clk_pin_i (clk_pin_i),
      .pt_clk_i  (pt_clk_i[k]),
      .rst_ni    (rst_ni),
      .areset_i  (areset_i[k]),
      .spreset_i (spreset_i),
      .sum_i     (sum_i[k]),
      .pl_mode_i (preload_i),
      .pl_hit_i  (hit),
      .pl_data_i (pad_i),
      .cfg_i     (cfg),
      .q_o       (q[k])
    );
  end

  omc_out_stage #(.NREG(NREG), .OSEL_W(OSEL_W)) u_out (
    .q_i      (q),
    .comb_i   (sum_i[0]),
    .osel_i   (cfg_osel_i),
    .inv_i    (cfg_inv_i),
    .oe_i     (oe_term_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );

  assign pin_fb_o = pad_i;
  assign reg_fb_o = q;
endmodule

// File: tb/omc_dual_cell_bench.sv
`timescale 1ns/100ps
module omc_dual_cell_bench;
  logic       clk = 1'b0;
  logic       pin_en = 1'b0;
  logic       clk_pin;
  logic       rst_n = 1'b0;
  logic [1:0] sum = '0, pt_clk = '0, areset = '0, t_mode = '0, pt_sel = '0;
  logic       spreset = 1'b0, inv = 1'b0, oe = 1'b0, preload = 1'b0, pl_sel = 1'b0, pad_in = 1'b0;
  logic [1:0] osel = '0;
  logic       pad_o, pad_oe, pin_fb;
  logic [1:0] reg_fb;
  logic [1:0] m;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign clk_pin = clk & pin_en;

  omc_dual_cell u_omc_dual_cell (
    .clk_pin_i(clk_pin), .rst_ni(rst_n), .sum_i(sum), .pt_clk_i(pt_clk),
    .areset_i(areset), .spreset_i(spreset), .cfg_t_mode_i(t_mode),
    .cfg_pt_clk_i(pt_sel), .cfg_osel_i(osel), .cfg_inv_i(inv),
    .oe_term_i(oe), .preload_i(preload), .preload_sel_i(pl_sel),
    .pad_i(pad_in), .pad_o(pad_o), .pad_oe_o(pad_oe), .pin_fb_o(pin_fb),
    .reg_fb_o(reg_fb)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ev 0: one pin clock edge; ev 1/2: one pulse on pt_clk[ev-1]
  task automatic fire(input int ev);
    @(negedge clk);
    if (ev == 0) begin
      pin_en = 1'b1;
      @(negedge clk);
      pin_en = 1'b0;
      #0.5;
    end else begin
      #0.5 pt_clk[ev-1] = 1'b1;
      #0.5 pt_clk[ev-1] = 1'b0;
      #0.5;
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0;
    #0.5 rst_n = 1'b1;
    #0.5;
  endtask

  // model of one event for both registers, from R1, R2, R3, R5
  task automatic model(input int ev);
    for (int k = 0; k < 2; k++) begin
      if ((pt_sel[k] == 1'b0 && ev == 0) || (pt_sel[k] == 1'b1 && ev == k + 1)) begin
        if (spreset)        m[k] = 1'b1;
        else if (t_mode[k]) m[k] = m[k] ^ sum[k];
        else                m[k] = sum[k];
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R7 reset state and polarity
    #1;
    chk("R7 regs in reset", {6'd0, reg_fb}, 8'd0);
    chk("R7 pad inv0", {7'd0, pad_o}, 8'd0);
    inv = 1'b1; #0.5;
    chk("R7 pad inv1", {7'd0, pad_o}, 8'd1);
    inv = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // sweep of every D/T and clock source combination: R1 R2 R3 R5
    for (int c = 0; c < 16; c++) begin
      t_mode = c[1:0];
      pt_sel = c[3:2];
      por();
      m = 2'b00;
      for (int s = 0; s < 12; s++) begin
        sum     = 2'((s * 3 + c) % 4);
        spreset = (s == 7);
        fire(s % 3);
        model(s % 3);
        chk("R1 R2 R3 R5 sweep", {6'd0, reg_fb}, {6'd0, m});
      end
      spreset = 1'b0;
    end

    // R6 preload with inverted polarity, D mode on pin clock
    t_mode = 2'b00; pt_sel = 2'b00; inv = 1'b1;
    por();
    preload = 1'b1; pl_sel = 1'b1; pad_in = 1'b1; sum = 2'b00;
    fire(0);
    chk("R6 preload reg1 raw level", {6'd0, reg_fb}, 8'b10);
    pl_sel = 1'b0; pad_in = 1'b1;
    fire(0);
    chk("R6 preload reg0, reg1 holds", {6'd0, reg_fb}, 8'b11);
    pl_sel = 1'b1; pad_in = 1'b0;
    fire(0);
    chk("R6 preload reg1 low, reg0 holds", {6'd0, reg_fb}, 8'b01);
    spreset = 1'b1;
    fire(0);
    chk("R6 preload beats preset", {6'd0, reg_fb}, 8'b01);
    spreset = 1'b0; preload = 1'b0;

    // R8 output select: reg0=1 reg1=0
    for (int o = 0; o < 4; o++) begin
      for (int v = 0; v < 2; v++) begin
        for (int s0 = 0; s0 < 2; s0++) begin
          logic srcv;
          osel = 2'(o); inv = v[0]; sum = {1'b0, s0[0]};
          #0.5;
          srcv = (o == 0) ? 1'b1 : (o == 1) ? 1'b0 : s0[0];
          chk("R8 pad select/polarity", {7'd0, pad_o}, {7'd0, srcv ^ v[0]});
          chk("R9 reg_fb independent of osel", {6'd0, reg_fb}, 8'b01);
        end
      end
    end

    // R9 enable and pad input path
    for (int p = 0; p < 4; p++) begin
      oe = p[0]; pad_in = p[1];
      #0.5;
      chk("R9 pad_oe follows term", {7'd0, pad_oe}, {7'd0, p[0]});
      chk("R9 pin_fb follows pad", {7'd0, pin_fb}, {7'd0, p[1]});
    end

    // R4 async reset: immediate, and beats preset
    osel = 2'd0; inv = 1'b0; sum = 2'b11;
    @(negedge clk);
    areset[0] = 1'b1;
    #0.5;
    chk("R4 clears without clock", {6'd0, reg_fb}, 8'b00);
    spreset = 1'b1;
    fire(0);
    chk("R4 held reset beats preset", {6'd0, reg_fb}, 8'b10);
    areset[0] = 1'b0; spreset = 1'b0;
    fire(0);
    chk("R1 after reset release", {6'd0, reg_fb}, 8'b11);
    chk("R8 pad from reg0", {7'd0, pad_o}, 8'd1);

    // R3 product-term clock selected: pin edges ignored
    pt_sel = 2'b11; sum = 2'b00;
    fire(0);
    chk("R3 pin edge ignored", {6'd0, reg_fb}, 8'b11);
    fire(2);
    chk("R3 pt1 only", {6'd0, reg_fb}, 8'b01);
    pt_sel = 2'b00;

    // R7 mid-run reset pulse with polarity
    inv = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk("R7 pulse clears both", {6'd0, reg_fb}, 8'b00);
    chk("R7 pad equals polarity", {7'd0, pad_o}, 8'd1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule